// File: doc/BRIEF.md
# Audio transmit sample FIFO

This block buffers playback samples on their way from a host register bus to a codec-side sink. Every host write is turned into one or two 20-bit, left-aligned samples. The padding depends on the selected sample size. In non-compact mode one write carries one sample. In compact mode one 32-bit write carries two 16-bit halves, and the low half is stored before the high half. The sink takes samples in stereo pairs through a valid/ready handshake, one 40-bit pair per cycle.

Draining does not start until the FIFO is at least half full. Once it starts, pairs keep leaving, oldest first, until the sink refuses one or fewer than two samples remain. The block keeps four status flags: empty, half-empty, full and underrun. These flags move on push and drain events rather than being decoded from the level. From them the block derives three interrupt sources and one masked interrupt line. A host command that flushes the FIFO, issued when the main interface enable is written low, restores the reset state.

Top module: `aud_txfifo`

## Requirements
- R1: The size code maps 0 to 16-bit, 1 to 18-bit, 2 to 20-bit and 3 to 12-bit samples. In non-compact mode the write word is shifted left by 4, 2, 0 or 8 bits for those codes, and the low 20 bits are stored.
- R2: With `compact_req` set and a 16-bit or 12-bit size, one write stores two samples: bits 15:0 first, then bits 31:16. Each half is shifted left by 8 for 12-bit size and by 4 for 16-bit size.
- R3: With `compact_req` set and an 18-bit or 20-bit size, the write is handled exactly as a non-compact write.
- R4: A single-sample write is accepted only when level < DEPTH. A two-sample write is accepted only when level + 2 < DEPTH. A rejected write changes neither the contents nor the flags.
- R5: `pair_valid` is high only while `tx_enable` is 1 and at least one bit of `slot_sel` is 1. A drain burst starts only when level >= DEPTH/2.
- R6: `pair_data` carries the oldest sample in bits 39:20 and the next one in bits 19:0. A burst continues while at least two samples remain and every offered pair is taken. After a refused pair, `pair_valid` drops until the level reaches DEPTH/2 again.
- R7: After an accepted push, a nonzero level clears `empty` and `underrun`. A level >= DEPTH/2 clears `half_empty`. A level >= DEPTH sets `full`.
- R8: After a pop, `full` is cleared. A level <= DEPTH/2 sets `half_empty`. A level of 0 sets `empty` and `underrun`.
- R9: After reset or a `flush` pulse, the FIFO is empty. The flags then read `empty`=1, `half_empty`=1, `full`=0 and `underrun`=0, and `int_src` reads 3'b110.
- R10: `int_src` bit 0 follows `underrun` and bit 1 follows `half_empty`. `irq` is the OR of `int_src & int_enable` and is registered, so an enable change shows one cycle later. A `ur_clear` pulse clears `underrun`.
- R11: `int_src` bit 2 (transmit complete) is 1 when the FIFO is empty and no burst is active. It therefore rises one cycle after the final pop of a burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Pulse: empty the FIFO and restore the reset flags |
| wr_en | input | 1 | Host sample write strobe |
| wr_data | input | 32 | Host write word |
| size_code | input | 2 | Sample size code (0:16, 1:18, 2:20, 3:12 bits) |
| compact_req | input | 1 | Request two 16-bit samples per write |
| tx_enable | input | 1 | Transmit enable |
| slot_sel | input | 2 | Output slot selection, any bit set allows draining |
| ur_clear | input | 1 | Pulse: clear the underrun flag |
| int_enable | input | 3 | Interrupt enables, bit order as `int_src` |
| pair_valid | output | 1 | Stereo pair offered to the sink |
| pair_ready | input | 1 | Sink accepts the offered pair |
| pair_data | output | 40 | {older sample, newer sample} |
| empty | output | 1 | FIFO empty flag |
| half_empty | output | 1 | Half-empty flag |
| full | output | 1 | Full flag |
| underrun | output | 1 | Sticky underrun flag |
| int_src | output | 3 | {transmit complete, transmit request, underrun} |
| irq | output | 1 | Masked interrupt line |

## Verification
The hardest state to reach from the ports is a burst that ends by refusal while the level is below half depth. The bench lets exactly three pairs go from a full FIFO with `pair_ready` held high, then drops `pair_ready`. It then shows that raising `pair_ready` again draws nothing until new writes bring the level back to the threshold. A second difficult point is the compact acceptance limit one entry below full. The bench reaches it by filling with single writes to DEPTH-3 and DEPTH-2 before a compact write. It then proves acceptance or rejection by counting the single writes needed to raise `full`.

// File: rtl/aud_txfifo_pkg.sv
package aud_txfifo_pkg;

   localparam int SAMPLE_W = 20;
   localparam int PAIR_W   = 2 * SAMPLE_W;

   // interrupt source bit positions
   localparam int IS_UR   = 0;
   localparam int IS_REQ  = 1;
   localparam int IS_DONE = 2;

   typedef enum logic [1:0] {
      SZ16 = 2'd0,
      SZ18 = 2'd1,
      SZ20 = 2'd2,
      SZ12 = 2'd3
   } size_e;

   function automatic logic [4:0] nc_shift(size_e s);
      case (s)
         SZ12:    return 5'd8;
         SZ16:    return 5'd4;
         SZ18:    return 5'd2;
         default: return 5'd0;
      endcase
   endfunction

   function automatic logic [SAMPLE_W-1:0] pad_single(logic [31:0] w, size_e s);
      logic [31:0] t;
      t = w << nc_shift(s);
      return t[SAMPLE_W-1:0];
   endfunction

   function automatic logic [SAMPLE_W-1:0] pad_half(logic [15:0] h, size_e s);
      logic [23:0] t;
      t = {8'h00, h} << ((s == SZ12) ? 5'd8 : 5'd4);
      return t[SAMPLE_W-1:0];
   endfunction

   function automatic logic compact_ok(size_e s);
      return (s == SZ16) || (s == SZ12);
   endfunction

endpackage

// File: rtl/aud_txfifo_pack.sv
module aud_txfifo_pack
   import aud_txfifo_pkg::*;
(
   input  logic [1:0]          size_code,
   input  logic                compact_req,
   input  logic [31:0]         wr_data,
   output logic                two_samples,
   output logic [SAMPLE_W-1:0] smp_first,
   output logic [SAMPLE_W-1:0] smp_second
);

   size_e                sz;
   logic [SAMPLE_W-1:0]  half_pad [2];

   assign sz          = size_e'(size_code);
   assign two_samples = compact_req && compact_ok(sz);

   for (genvar g = 0; g < 2; g++) begin : g_lane
      assign half_pad[g] = pad_half(wr_data[16*g +: 16], sz);
   end

   assign smp_first  = two_samples ? half_pad[0] : pad_single(wr_data, sz);
   assign smp_second = half_pad[1];

endmodule

// File: rtl/aud_txfifo_store.sv
module aud_txfifo_store
   import aud_txfifo_pkg::*;
#(
   parameter int DEPTH = 8,
   localparam int AW = $clog2(DEPTH),
   localparam int LW = AW + 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                flush,
   input  logic                put_one,
   input  logic                put_two,
   input  logic [SAMPLE_W-1:0] in_first,
   input  logic [SAMPLE_W-1:0] in_second,
   input  logic                take_pair,
   output logic [SAMPLE_W-1:0] out_old,
   output logic [SAMPLE_W-1:0] out_new,
   output logic [LW-1:0]       level,
   output logic [LW-1:0]       level_nx
);

   logic [SAMPLE_W-1:0] mem [DEPTH];
   logic [AW-1:0]       wp, rp;
   logic [AW-1:0]       wp_inc, rp_inc;
   logic [LW-1:0]       add_n, sub_n;

   assign wp_inc = wp + AW'(1);
   assign rp_inc = rp + AW'(1);

   assign add_n    = put_two ? LW'(2) : (put_one ? LW'(1) : '0);
   assign sub_n    = take_pair ? LW'(2) : '0;
   assign level_nx = flush ? '0 : (level + add_n - sub_n);

   always_ff @(posedge clk) begin
      if (!flush && (put_one || put_two)) mem[wp] <= in_first;
      if (!flush && put_two)              mem[wp_inc] <= in_second;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp    <= '0;
         rp    <= '0;
         level <= '0;
      end else if (flush) begin
         wp    <= '0;
         rp    <= '0;
         level <= '0;
      end else begin
         wp    <= wp + add_n[AW-1:0];
         rp    <= rp + sub_n[AW-1:0];
         level <= level_nx;
      end
   end

   assign out_old = mem[rp];
   assign out_new = mem[rp_inc];

endmodule

// File: rtl/aud_txfifo_drain.sv
module aud_txfifo_drain #(
   parameter int DEPTH = 8,
   localparam int LW = $clog2(DEPTH) + 1,
   localparam logic [LW-1:0] HALF = LW'(DEPTH / 2)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic          tx_enable,
   input  logic [1:0]    slot_sel,
   input  logic [LW-1:0] level,
   input  logic          pair_ready,
   output logic          pair_valid,
   output logic          take_pair
);

   logic burst_q;
   logic gate_ok;

   assign gate_ok    = tx_enable && (|slot_sel) && !flush;
   assign pair_valid = gate_ok && (level >= LW'(2)) && ((level >= HALF) || burst_q);
   assign take_pair  = pair_valid && pair_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     burst_q <= 1'b0;
      else if (flush) burst_q <= 1'b0;
      else            burst_q <= take_pair;
   end

endmodule

// File: rtl/aud_txfifo_status.sv
module aud_txfifo_status
   import aud_txfifo_pkg::*;
#(
   parameter int DEPTH = 8,
   localparam int LW = $clog2(DEPTH) + 1,
   localparam logic [LW-1:0] HALF = LW'(DEPTH / 2),
   localparam logic [LW-1:0] TOP  = LW'(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic          pushed,
   input  logic          popped,
   input  logic          burst_nx,
   input  logic [LW-1:0] level_nx,
   input  logic          ur_clear,
   input  logic [2:0]    int_enable,
   output logic          empty,
   output logic          half_empty,
   output logic          full,
   output logic          underrun,
   output logic [2:0]    int_src,
   output logic          irq
);

   logic       e_nx, h_nx, f_nx, u_nx;
   logic [2:0] src_nx;

   always_comb begin
      e_nx = empty;
      h_nx = half_empty;
      f_nx = full;
      u_nx = underrun;
      if (ur_clear) u_nx = 1'b0;
      if (pushed) begin
         if (level_nx != '0) begin
            e_nx = 1'b0;
            u_nx = 1'b0;
         end
         if (level_nx >= HALF) h_nx = 1'b0;
         if (level_nx >= TOP)  f_nx = 1'b1;
      end
      if (popped) begin
         f_nx = 1'b0;
         if (level_nx <= HALF) h_nx = 1'b1;
         if (level_nx == '0) begin
            e_nx = 1'b1;
            u_nx = 1'b1;
         end
      end
      if (flush) begin
         e_nx = 1'b1;
         h_nx = 1'b1;
         f_nx = 1'b0;
         u_nx = 1'b0;
      end
      src_nx          = '0;
      src_nx[IS_UR]   = u_nx;
      src_nx[IS_REQ]  = h_nx;
      src_nx[IS_DONE] = e_nx && !(burst_nx && !flush);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         empty      <= 1'b1;
         half_empty <= 1'b1;
         full       <= 1'b0;
         underrun   <= 1'b0;
         int_src    <= 3'b110;
         irq        <= 1'b0;
      end else begin
         empty      <= e_nx;
         half_empty <= h_nx;
         full       <= f_nx;
         underrun   <= u_nx;
         int_src    <= src_nx;
         irq        <= |(src_nx & int_enable);
      end
   end

endmodule

// File: rtl/aud_txfifo.sv
module aud_txfifo
   import aud_txfifo_pkg::*;
#(
   parameter int DEPTH = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              wr_en,
   input  logic [31:0]       wr_data,
   input  logic [1:0]        size_code,
   input  logic              compact_req,
   input  logic              tx_enable,
   input  logic [1:0]        slot_sel,
   input  logic              ur_clear,
   input  logic [2:0]        int_enable,
   output logic              pair_valid,
   input  logic              pair_ready,
   output logic [PAIR_W-1:0] pair_data,
   output logic              empty,
   output logic              half_empty,
   output logic              full,
   output logic              underrun,
   output logic [2:0]        int_src,
   output logic              irq
);

   localparam int LW = $clog2(DEPTH) + 1;
   localparam logic [LW:0] LIMIT = (LW+1)'(DEPTH);

   if (DEPTH < 8 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("aud_txfifo: DEPTH must be a power of two of at least 8");
   end

   logic                two_samples;
   logic [SAMPLE_W-1:0] smp_first, smp_second;
   logic                put_one, put_two;
   logic                take_pair;
   logic [LW-1:0]       level, level_nx;
   logic [SAMPLE_W-1:0] out_old, out_new;
   logic [LW:0]         level_ext;

   assign level_ext = {1'b0, level};
   assign put_one   = wr_en && !flush && !two_samples && (level_ext < LIMIT);
   assign put_two   = wr_en && !flush &&  two_samples && ((level_ext + (LW+1)'(2)) < LIMIT);

   aud_txfifo_pack u_pack (
      .size_code   (size_code),
      .compact_req (compact_req),
      .wr_data     (wr_data),
      .two_samples (two_samples),
      .smp_first   (smp_first),
      .smp_second  (smp_second)
   );

   aud_txfifo_store #(.DEPTH(DEPTH)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (flush),
      .put_one   (put_one),
      .put_two   (put_two),
      .in_first  (smp_first),
      .in_second (smp_second),
      .take_pair (take_pair),
      .out_old   (out_old),
      .out_new   (out_new),
      .level     (level),
      .level_nx  (level_nx)
   );

   aud_txfifo_drain #(.DEPTH(DEPTH)) u_drain (
      .clk        (clk),
      .rst_n      (rst_n),
      .flush      (flush),
      .tx_enable  (tx_enable),
      .slot_sel   (slot_sel),
      .level      (level),
      .pair_ready (pair_ready),
      .pair_valid (pair_valid),
      .take_pair  (take_pair)
   );

   aud_txfifo_status #(.DEPTH(DEPTH)) u_status (
      .clk        (clk),
      .rst_n      (rst_n),
      .flush      (flush),
      .pushed     (put_one || put_two),
      .popped     (take_pair),
      .burst_nx   (take_pair),
      .level_nx   (level_nx),
      .ur_clear   (ur_clear),
      .int_enable (int_enable),
      .empty      (empty),
      .half_empty (half_empty),
      .full       (full),
      .underrun   (underrun),
      .int_src    (int_src),
      .irq        (irq)
   );

   assign pair_data = {out_old, out_new};

endmodule

// File: rtl/aud_txfifo_chk.sv
module aud_txfifo_chk #(
   parameter int DEPTH = 8,
   localparam int LW = $clog2(DEPTH) + 1
) (
   input logic          clk,
   input logic          rst_n,
   input logic          flush,
   input logic          tx_enable,
   input logic [1:0]    slot_sel,
   input logic [2:0]    int_enable,
   input logic          pair_valid,
   input logic          pair_ready,
   input logic          empty,
   input logic          half_empty,
   input logic          full,
   input logic          underrun,
   input logic [2:0]    int_src,
   input logic          irq,
   input logic [LW-1:0] level
);

   // R4
   level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      level <= LW'(DEPTH));

   // R5
   valid_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pair_valid |-> (tx_enable && (|slot_sel)));

   // R6
   refuse_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pair_valid && !pair_ready) |=> (!pair_valid || level >= LW'(DEPTH / 2)));

   // R7
   full_not_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
      full |-> !half_empty);

   // R8
   valid_not_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pair_valid |-> !empty);

   // R9
   flush_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (empty && half_empty && !full && !underrun && !pair_valid));

   // R10
   irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (irq == (|(int_src & $past(int_enable)))));

   // R10
   ur_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      int_src[0] == underrun);

   // R11
   done_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(int_src[2]) |-> empty);

endmodule

bind aud_txfifo aud_txfifo_chk #(.DEPTH(DEPTH)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .flush      (flush),
   .tx_enable  (tx_enable),
   .slot_sel   (slot_sel),
   .int_enable (int_enable),
   .pair_valid (pair_valid),
   .pair_ready (pair_ready),
   .empty      (empty),
   .half_empty (half_empty),
   .full       (full),
   .underrun   (underrun),
   .int_src    (int_src),
   .irq        (irq),
   .level      (level)
);

// File: tb/aud_txfifo_bench.sv
`timescale 1ns/1ps
module aud_txfifo_bench;

   localparam int DEPTH = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        flush = 1'b0;
   logic        wr_en = 1'b0;
   logic [31:0] wr_data = '0;
   logic [1:0]  size_code = '0;
   logic        compact_req = 1'b0;
   logic        tx_enable = 1'b0;
   logic [1:0]  slot_sel = '0;
   logic        ur_clear = 1'b0;
   logic [2:0]  int_enable = '0;
   logic        pair_ready = 1'b0;
   logic        pair_valid;
   logic [39:0] pair_data;
   logic        empty, half_empty, full, underrun, irq;
   logic [2:0]  int_src;

   int n_chk = 0;
   int n_fail = 0;
   int pops = 0;
   logic [39:0] pairs [16];

   always #2 clk = ~clk;

   aud_txfifo #(.DEPTH(DEPTH)) u_aud_txfifo (
      .clk(clk), .rst_n(rst_n), .flush(flush), .wr_en(wr_en), .wr_data(wr_data),
      .size_code(size_code), .compact_req(compact_req), .tx_enable(tx_enable),
      .slot_sel(slot_sel), .ur_clear(ur_clear), .int_enable(int_enable),
      .pair_valid(pair_valid), .pair_ready(pair_ready), .pair_data(pair_data),
      .empty(empty), .half_empty(half_empty), .full(full), .underrun(underrun),
      .int_src(int_src), .irq(irq)
   );

   always @(posedge clk) begin
      if (pair_valid && pair_ready) begin
         if (pops < 16) pairs[pops] = pair_data;
         pops = pops + 1;
      end
   end

   typedef struct packed {
      logic [1:0]  sz;
      logic        cmp;
      logic        two_wr;
      logic [31:0] w0;
      logic [31:0] w1;
      logic [39:0] exp_pair;
   } vec_t;

   localparam vec_t VECS [8] = '{
      '{2'd0, 1'b0, 1'b1, 32'h0000ABCD, 32'hFFFF1234, {20'hABCD0, 20'h12340}},
      '{2'd1, 1'b0, 1'b1, 32'h0003FFFF, 32'h00012345, {20'hFFFFC, 20'h48D14}},
      '{2'd2, 1'b0, 1'b1, 32'hFFF12345, 32'h000ABCDE, {20'h12345, 20'hABCDE}},
      '{2'd3, 1'b0, 1'b1, 32'h00000ABC, 32'h00012345, {20'hABC00, 20'h34500}},
      '{2'd0, 1'b1, 1'b0, 32'h1234ABCD, 32'h0,        {20'hABCD0, 20'h12340}},
      '{2'd3, 1'b1, 1'b0, 32'h0FED0123, 32'h0,        {20'h12300, 20'hFED00}},
      '{2'd2, 1'b1, 1'b1, 32'h000FFFFF, 32'h00000001, {20'hFFFFF, 20'h00001}},
      '{2'd1, 1'b1, 1'b1, 32'h00000001, 32'h00010000, {20'h00004, 20'h40000}}
   };

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [31:0] d);
      wr_en = 1'b1;
      wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic do_flush();
      flush = 1'b1;
      @(negedge clk);
      flush = 1'b0;
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      finish_run();
   end

   initial begin
      int p0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R9 reset state
      chk("R9 empty", empty, 1);
      chk("R9 half_empty", half_empty, 1);
      chk("R9 full", full, 0);
      chk("R9 underrun", underrun, 0);
      chk("R9 int_src", int_src, 3'b110);
      chk("R9 pair_valid", pair_valid, 0);

      // R1 R2 R3 packing table
      for (int i = 0; i < 8; i++) begin
         string tag;
         size_code = VECS[i].sz;
         compact_req = VECS[i].cmp;
         do_flush();
         wr(VECS[i].w0);
         if (VECS[i].two_wr) wr(VECS[i].w1);
         if (VECS[i].cmp && !VECS[i].two_wr) tag = "R2 compact pair";
         else if (VECS[i].cmp) tag = "R3 forced single";
         else tag = "R1 padded pair";
         chk(tag, pair_data, VECS[i].exp_pair);
         chk("R7 empty cleared", empty, 0);
      end

      // R4 single-sample overflow and R6 drain order
      size_code = 2'd2;
      compact_req = 1'b0;
      do_flush();
      for (int i = 1; i <= 7; i++) wr(i);
      chk("R4 not full at 7", full, 0);
      wr(8);
      chk("R4 full at 8", full, 1);
      chk("R7 half cleared", half_empty, 0);
      wr(9);
      pops = 0;
      tx_enable = 1'b1;
      slot_sel = 2'b01;
      pair_ready = 1'b1;
      repeat (6) @(negedge clk);
      chk("R4 pair count", pops, 4);
      chk("R6 first pair", pairs[0], {20'd1, 20'd2});
      chk("R4 ninth dropped", pairs[3], {20'd7, 20'd8});
      chk("R8 empty", empty, 1);
      chk("R8 underrun", underrun, 1);
      chk("R8 half set", half_empty, 1);
      chk("R8 full cleared", full, 0);
      tx_enable = 1'b0;
      pair_ready = 1'b0;
      wr(32'h5);
      chk("R7 push clears underrun", underrun, 0);

      // R4 compact limit
      do_flush();
      for (int i = 0; i < 5; i++) wr(i);
      size_code = 2'd0;
      compact_req = 1'b1;
      wr(32'h00020001);
      chk("R4 compact accepted at 5", full, 0);
      size_code = 2'd2;
      compact_req = 1'b0;
      wr(32'h3);
      chk("R4 full after compact", full, 1);
      do_flush();
      for (int i = 0; i < 6; i++) wr(i);
      size_code = 2'd0;
      compact_req = 1'b1;
      wr(32'h00020001);
      chk("R4 compact rejected at 6", full, 0);
      size_code = 2'd2;
      compact_req = 1'b0;
      wr(32'h3);
      chk("R4 level 7 not full", full, 0);
      wr(32'h4);
      chk("R4 full at 8 after drop", full, 1);

      // R5 gating
      do_flush();
      for (int i = 0; i < 3; i++) wr(i);
      chk("R7 half stays at 3", half_empty, 1);
      tx_enable = 1'b1;
      slot_sel = 2'b01;
      chk("R5 below half no valid", pair_valid, 0);
      wr(32'h3);
      chk("R7 half cleared at 4", half_empty, 0);
      chk("R5 valid at half", pair_valid, 1);
      slot_sel = 2'b00;
      #0.5;
      chk("R5 no slot no valid", pair_valid, 0);
      slot_sel = 2'b10;
      #0.5;
      chk("R5 slot4 valid", pair_valid, 1);
      tx_enable = 1'b0;
      #0.5;
      chk("R5 disabled no valid", pair_valid, 0);
      tx_enable = 1'b1;
      @(negedge clk);

      // R8 R11 drain of four
      pair_ready = 1'b1;
      @(negedge clk);
      chk("R8 half set at 2", half_empty, 1);
      chk("R6 burst continues", pair_valid, 1);
      @(negedge clk);
      chk("R8 empty at 0", empty, 1);
      chk("R10 ur source", int_src[0], 1);
      chk("R11 done waits for busy", int_src[2], 0);
      @(negedge clk);
      chk("R11 done raised", int_src[2], 1);
      chk("R6 no valid when empty", pair_valid, 0);

      // R10 interrupts
      int_enable = 3'b001;
      @(negedge clk);
      chk("R10 irq ur", irq, 1);
      ur_clear = 1'b1;
      @(negedge clk);
      ur_clear = 1'b0;
      chk("R10 ur cleared", underrun, 0);
      chk("R10 irq off", irq, 0);
      int_enable = 3'b010;
      @(negedge clk);
      chk("R10 irq request", irq, 1);
      int_enable = 3'b100;
      @(negedge clk);
      chk("R10 irq done", irq, 1);
      wr(32'h1);
      chk("R11 done cleared by push", int_src[2], 0);
      chk("R10 irq follows done", irq, 0);
      int_enable = 3'b000;

      // R6 refusal
      tx_enable = 1'b0;
      do_flush();
      for (int i = 0; i < 8; i++) wr(i);
      p0 = pops;
      tx_enable = 1'b1;
      slot_sel = 2'b01;
      pair_ready = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      pair_ready = 1'b0;
      chk("R6 three pops", pops - p0, 3);
      @(negedge clk);
      chk("R6 valid drops after refusal", pair_valid, 0);
      pair_ready = 1'b1;
      repeat (3) @(negedge clk);
      chk("R6 no restart below half", pops - p0, 3);
      chk("R6 level kept", empty, 0);
      wr(32'h10);
      wr(32'h11);
      repeat (4) @(negedge clk);
      chk("R6 restart at half", pops - p0, 5);
      chk("R6 last pair", pairs[p0 + 4], {20'h10, 20'h11});
      pair_ready = 1'b0;
      tx_enable = 1'b0;

      // R9 flush mid fill
      for (int i = 0; i < 5; i++) wr(i);
      do_flush();
      chk("R9 flush empty", empty, 1);
      chk("R9 flush half", half_empty, 1);
      chk("R9 flush full", full, 0);
      chk("R9 flush underrun", underrun, 0);
      chk("R9 flush int_src", int_src, 3'b110);

      finish_run();
   end

endmodule